// File: doc/BRIEF.md
# Dual Page Buffer Count Loader

This block is the command-side front end for a pair of 256-byte page buffers in a flash device. The command decoder, which is outside this block, raises a load strobe when a buffer-write command is seen. The loader then takes a two-byte item count from the next two host write cycles and steers the items that follow into whichever of the two buffers is active. The order of the two count bytes is chosen by the host address bit on the first count cycle. The loader flips that bit itself for the second count byte, so the host address bit is ignored on that cycle.

The count is held as length minus one, so a low count byte of zero means one item. In byte-wide mode each item is one byte. In word-wide mode each item is one 16-bit word, only bus bits 7:0 carry the count bytes, and the buffer holds at most 128 words. If the high count byte is not zero, or if a word count would overflow the buffer, the loader raises an error flag and writes nothing. A separate swap strobe, accepted only while the loader is idle, toggles which buffer is active. A one-cycle done pulse follows the last item.

Top module: `pgbuf_loader`

## Requirements
- R1: After reset, act_buf is 0, and buf_we, load_done and load_err are all 0.
- R2: On the first count cycle, a0=0 stores host_data[7:0] as the low count byte and a0=1 stores it as the high count byte. The second count cycle stores the other byte, whatever a0 is on that cycle.
- R3: A low count byte of N produces exactly N+1 buffer writes.
- R4: host_data[15:8] has no effect on the stored count in either bus mode.
- R5: Data writes are taken on the write strobes that follow the second count cycle. buf_we is high in the same cycle as the strobe, and buf_wdata equals host_data. buf_addr starts at 0 and steps by 1 when byte_mode=1, or by 2 with buf_word=1 when byte_mode=0.
- R6: A nonzero high count byte raises load_err in the cycle after the second count cycle. No write follows, and load_err stays high until the next load strobe clears it.
- R7: With byte_mode=0, a low count byte above 127 is rejected in the same way as R6.
- R8: load_done is high for exactly one cycle, in the cycle after the final item's strobe. The loader is then idle, and further write strobes cause no writes.
- R9: cmd_swap toggles act_buf while the loader is idle, and has no effect during a load. Writes are tagged with act_buf through buf_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_load | input | 1 | Decoded buffer-write command strobe |
| cmd_swap | input | 1 | Decoded buffer swap command strobe |
| wr_stb | input | 1 | Host write cycle strobe |
| a0 | input | 1 | Host address bit 0 |
| byte_mode | input | 1 | 1 = byte-wide bus, 0 = word-wide bus |
| host_data | input | 16 | Host data bus |
| act_buf | output | 1 | Index of the active page buffer |
| buf_we | output | 1 | Buffer write enable |
| buf_sel | output | 1 | Buffer targeted by the current write |
| buf_addr | output | 8 | Byte address within the buffer |
| buf_wdata | output | 16 | Data written to the buffer |
| buf_word | output | 1 | Current write is a 16-bit word |
| load_done | output | 1 | One-cycle pulse after the final item |
| load_err | output | 1 | Count was rejected and the load aborted |

## Verification
Loads are run with both count orders, and the second-cycle a0 is deliberately left uncomplemented. This tells a loader that flips a0 itself apart from one that follows the pin. Garbage is placed in the upper data byte of the count cycles, which exposes any leak of bits 15:8 into the count. The counts tried are 0, small values, 127 words, 128 words and 255 bytes, which separates length-minus-one handling from off-by-one and word-overflow faults. A nonzero high byte, and swaps issued both while idle and in mid-load, separate the abort and swap-gating paths.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CNT1, ST_CNT2, ST_DATA} ld_state_t;

  // number of items encoded by a stored low count byte
  function automatic int unsigned items_of(input logic [7:0] lo);
    return int'(lo) + 1;
  endfunction

  // count accepted: high byte zero and total size within the buffer
  function automatic logic count_fits(input logic [7:0] hi, input logic [7:0] lo,
                                      input logic word, input int unsigned bytes);
    int unsigned need;
    need = word ? items_of(lo) * 2 : items_of(lo);
    return (hi == 8'h00) && (need <= bytes);
  endfunction
endpackage

// File: rtl/pgbuf_count_capture.sv
module pgbuf_count_capture #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_first,
  input  logic          cap_second,
  input  logic          a0,
  input  logic [CW-1:0] byte_in,
  output logic [CW-1:0] cnt_lo,
  output logic [CW-1:0] cnt_hi
);
  logic [CW-1:0] lo_q, hi_q;
  logic          first_hi_q;   // first byte went to the high half

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      first_hi_q <= 1'b0;
    end else if (cap_first) begin
      first_hi_q <= a0;
      if (a0) hi_q <= byte_in;
      else    lo_q <= byte_in;
    end else if (cap_second) begin
      // second byte goes to the half selected by the flipped first a0
      if (first_hi_q) lo_q <= byte_in;
      else            hi_q <= byte_in;
    end
  end

  // complete count, including the byte arriving on the second cycle
  assign cnt_lo = (cap_second && first_hi_q)  ? byte_in : lo_q;
  assign cnt_hi = (cap_second && !first_hi_q) ? byte_in : hi_q;
endmodule

// File: rtl/pgbuf_write_ptr.sv
module pgbuf_write_ptr #(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] init_left,
  input  logic          step_en,
  input  logic          word_mode,
  output logic [AW-1:0] addr,
  output logic          last
);
  logic [AW-1:0] ptr_q;
  logic [CW-1:0] left_q;
  logic [AW-1:0] step;

  assign step = word_mode ? AW'(2) : AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      left_q <= '0;
    end else if (start) begin
      ptr_q  <= '0;
      left_q <= init_left;
    end else if (step_en) begin
      ptr_q  <= ptr_q + step;
      left_q <= left_q - CW'(1);
    end
  end

  assign addr = ptr_q;
  assign last = (left_q == '0);
endmodule

// File: rtl/pgbuf_select.sv
module pgbuf_select (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle,
  output logic sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel <= 1'b0;
    else if (toggle) sel <= ~sel;
  end
endmodule

// File: rtl/pgbuf_loader.sv
module pgbuf_loader
  import pgbuf_pkg::*;
#(
  parameter int BUF_BYTES = 256,
  parameter int DW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_load,
  input  logic          cmd_swap,
  input  logic          wr_stb,
  input  logic          a0,
  input  logic          byte_mode,
  input  logic [DW-1:0] host_data,
  output logic          act_buf,
  output logic          buf_we,
  output logic          buf_sel,
  output logic [$clog2(BUF_BYTES)-1:0] buf_addr,
  output logic [DW-1:0] buf_wdata,
  output logic          buf_word,
  output logic          load_done,
  output logic          load_err
);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int CW = 8;

  ld_state_t     st_q;
  logic          word_q, err_q, done_q;
  logic [CW-1:0] cnt_lo, cnt_hi;
  logic          first_cyc, second_cyc, data_cyc;
  logic          count_ok, start_data, abort_load, swap_req, last_item;
  logic [AW-1:0] ptr_addr;

  assign first_cyc  = wr_stb && (st_q == ST_CNT1);
  assign second_cyc = wr_stb && (st_q == ST_CNT2);
  assign data_cyc   = wr_stb && (st_q == ST_DATA);
  assign count_ok   = count_fits(cnt_hi, cnt_lo, word_q, BUF_BYTES);
  assign start_data = second_cyc && count_ok;
  assign abort_load = second_cyc && !count_ok;
  assign swap_req   = cmd_swap && (st_q == ST_IDLE);

  pgbuf_count_capture #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cap_first(first_cyc), .cap_second(second_cyc),
    .a0(a0), .byte_in(host_data[CW-1:0]), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
  );

  pgbuf_write_ptr #(.AW(AW), .CW(CW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .start(start_data), .init_left(cnt_lo),
    .step_en(data_cyc), .word_mode(word_q), .addr(ptr_addr), .last(last_item)
  );

  pgbuf_select u_sel (.clk(clk), .rst_n(rst_n), .toggle(swap_req), .sel(act_buf));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      word_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= data_cyc && last_item;
      unique case (st_q)
        ST_IDLE: if (cmd_load) begin
          st_q   <= ST_CNT1;
          word_q <= !byte_mode;
          err_q  <= 1'b0;
        end
        ST_CNT1: if (first_cyc) st_q <= ST_CNT2;
        ST_CNT2: if (second_cyc) begin
          st_q  <= count_ok ? ST_DATA : ST_IDLE;
          err_q <= abort_load;
        end
        ST_DATA: if (data_cyc && last_item) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign buf_we    = data_cyc;
  assign buf_sel   = act_buf;
  assign buf_addr  = ptr_addr;
  assign buf_wdata = host_data;
  assign buf_word  = word_q;
  assign load_done = done_q;
  assign load_err  = err_q;

  // R6: a rejected high count byte raises the error flag next cycle
  a_r6_abort_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (second_cyc && cnt_hi != '0) |=> load_err);
  // R6: no buffer write while the error flag is up
  a_r6_no_write_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |-> !buf_we);
  // R5: word writes land on even byte addresses
  a_r5_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && buf_word) |-> !buf_addr[0]);
  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);
  // R9: swap while idle toggles the active buffer
  a_r9_swap_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_swap && st_q == ST_IDLE) |=> (act_buf != $past(act_buf)));
  // R9: active buffer frozen during a load
  a_r9_swap_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> $stable(act_buf));
endmodule

// File: tb/pgbuf_loader_tb.sv
module pgbuf_loader_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cmd_load, cmd_swap, wr_stb, a0, byte_mode;
  logic [15:0] host_data;
  logic act_buf, buf_we, buf_sel, buf_word, load_done, load_err;
  logic [7:0] buf_addr;
  logic [15:0] buf_wdata;

  int n_chk = 0, n_bad = 0;
  logic exp_buf = 1'b0;

  typedef struct { logic [7:0] addr; logic [15:0] data; logic word; logic sel; } wr_t;
  wr_t exp_q[$];

  pgbuf_loader u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_swap(cmd_swap),
    .wr_stb(wr_stb), .a0(a0), .byte_mode(byte_mode), .host_data(host_data),
    .act_buf(act_buf), .buf_we(buf_we), .buf_sel(buf_sel), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .buf_word(buf_word), .load_done(load_done), .load_err(load_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every write must match the next scoreboard entry
  always @(negedge clk) begin
    if (rst_n && buf_we) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R6/R8 unexpected write actual=addr %0h expected=none", buf_addr);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        chk("R5 addr", 32'(buf_addr), 32'(e.addr));
        chk("R5 data", 32'(buf_wdata), 32'(e.data));
        chk("R5 width", 32'(buf_word), 32'(e.word));
        chk("R9 buffer", 32'(buf_sel), 32'(e.sel));
      end
    end
  end

  task automatic cyc(input logic ld, input logic sw, input logic wr,
                     input logic a, input logic [15:0] d);
    @(posedge clk); #1;
    cmd_load = ld; cmd_swap = sw; wr_stb = wr; a0 = a; host_data = d;
  endtask

  task automatic swap_idle();
    cyc(0, 1, 0, 0, 16'h0);
    exp_buf = ~exp_buf;
    cyc(0, 0, 0, 0, 16'h0);
    @(negedge clk);
    chk("R9 swap idle", 32'(act_buf), 32'(exp_buf));
  endtask

  task automatic run_load(input logic bm, input logic f, input logic [7:0] lo,
                          input logic [7:0] hi, input logic [7:0] junk, input logic sw_mid);
    logic word, ok;
    word = !bm;
    ok = (hi == 8'h00) && (word ? (lo < 8'd128) : 1'b1);
    byte_mode = bm;
    cyc(1, 0, 0, 0, 16'h0);
    if (sw_mid) begin
      cyc(0, 1, 0, 0, 16'h0);  // swap during load: must be ignored (R9)
    end
    // R2: first count byte, order chosen by a0; R4: junk in upper byte
    cyc(0, 0, 1, f, {junk, f ? hi : lo});
    @(negedge clk);
    chk("R6 err cleared by load", 32'(load_err), 32'd0);
    // second count byte, a0 left uncomplemented on purpose (R2)
    cyc(0, 0, 1, f, {~junk, f ? lo : hi});
    if (ok) begin
      for (int i = 0; i <= int'(lo); i++) begin
        wr_t e;
        e.addr = 8'(word ? i * 2 : i);
        e.data = 16'(i * 37 + int'(lo)) ^ {junk, 8'h5A};
        e.word = word;
        e.sel  = exp_buf;
        exp_q.push_back(e);
        cyc(0, 0, 1, i[0], e.data);
      end
    end
    cyc(0, 0, 0, 0, 16'h0);
    @(negedge clk);
    chk("R8 done pulse", 32'(load_done), 32'(ok));
    chk(ok ? "R6 no error" : "R6/R7 error flag", 32'(load_err), 32'(!ok));
    chk("R3 item count", 32'(exp_q.size()), 32'd0);
    chk("R9 buffer held", 32'(act_buf), 32'(exp_buf));
    // stray strobes after done or abort must not write (R8, R6)
    cyc(0, 0, 1, 0, 16'hDEAD);
    cyc(0, 0, 1, 1, 16'hBEEF);
    cyc(0, 0, 0, 0, 16'h0);
    @(negedge clk);
    chk("R8 done cleared", 32'(load_done), 32'd0);
    chk("R6 err sticky", 32'(load_err), 32'(!ok));
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; cmd_load = 0; cmd_swap = 0; wr_stb = 0; a0 = 0;
    byte_mode = 1; host_data = 16'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 act_buf", 32'(act_buf), 32'd0);
    chk("R1 buf_we", 32'(buf_we), 32'd0);
    chk("R1 done", 32'(load_done), 32'd0);
    chk("R1 err", 32'(load_err), 32'd0);

    run_load(1, 0, 8'd3,   8'h00, 8'h00, 0);  // R2 low first, R3 four bytes
    run_load(1, 1, 8'd0,   8'h00, 8'hAA, 0);  // R2 high first, R3 single item
    run_load(0, 0, 8'd5,   8'h00, 8'hFF, 0);  // R4 x16 junk upper, R5 word step
    swap_idle();                               // R9
    run_load(0, 1, 8'd127, 8'h00, 8'h3C, 1);  // R7 max words, R9 mid-load swap
    run_load(0, 0, 8'd128, 8'h00, 8'h00, 0);  // R7 word overflow rejected
    run_load(1, 0, 8'd255, 8'h00, 8'h81, 0);  // R3 full byte buffer
    run_load(1, 1, 8'd2,   8'h01, 8'h00, 0);  // R6 nonzero high byte
    swap_idle();                               // R9 back to buffer 0
    run_load(1, 0, 8'd1,   8'h00, 8'hC3, 0);  // R6 err cleared, normal again

    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule